// File: doc/BRIEF.md
# Task-event UART register controller

This block is the software-facing register layer of a small UART. Software never sets a mode bit to start or stop the line. It writes the value 1 to a task word, and the block changes its transmitter-started or receiver-started state. Progress is reported through single-bit event flags: a received byte, a sent byte, a line error and a receive timeout. Each flag can be routed to one shared interrupt line through a mask. The mask can be written whole, OR-set or AND-cleared through three separate words.

The whole peripheral is gated by an enable word that only accepts a specific code. The serial side is reduced to a few signals:
- a byte to send, with a busy indication;
- a send-done pulse from a built-in cycle-count transmit stub;
- a byte-received strobe with its data;
- a break indication.

The bus is word-addressed and 32 bits wide. A read returns its data on the clock edge after it is requested.

Top module: `uart_taskreg_ctrl`

## Requirements
- R1: The enable word (word 0x140) turns the peripheral on only when written with exactly 4. Any other nonzero value leaves the enabled state unchanged. Writing 0 turns it off and also performs the full stop described in R6.
- R2: While the peripheral is off, every read returns 0 and every write is ignored, except a write to the enable word.
- R3: The interrupt mask has bit 0 = byte received, bit 1 = byte sent, bit 2 = error and bit 3 = receive timeout. Word 0xC0 loads the mask directly, word 0xC1 ORs the written bits into it, and word 0xC2 clears the written bits. A read of any of the three returns the mask in bits 3:0.
- R4: `irq` is the OR of each event flag ANDed with its mask bit. It is registered and changes on the same clock edge as the flag or mask change that causes it.
- R5: The start-receive task (word 0x00) and start-transmit task (word 0x02) act only when written with exactly 1. `rx_running` shows the receiver-started state.
- R6: Writing 1 to stop-receive (word 0x01) or to suspend (word 0x07), or disabling, clears receiver-started and sets the timeout flag. Suspend and disabling also clear transmitter-started. Writing 1 to stop-transmit (word 0x03) clears only transmitter-started and leaves the timeout flag untouched.
- R7: A write to the transmit-data word (word 0x147) is accepted only while the transmitter is started and no byte is pending. An accepted write latches the byte on `tx_byte` and raises `tx_active`. A write that is not accepted leaves both unchanged.
- R8: For an accepted byte, `tx_done` pulses on the TX_CYCLES-th edge after the accepting edge. On the next edge the byte-sent flag sets and `tx_active` falls, and from then on a new byte is accepted.
- R9: The error-source word (word 0x120, bits 1:0) is write-one-to-clear. A cycle with `rx_break` high sets both bits and the error flag, and this takes priority over a clear in the same cycle.
- R10: The event words are byte received (word 0x42), byte sent (word 0x47), error (word 0x49) and timeout (word 0x51), and they read as 0 or 1. The last three take the value (written data != 0). The byte-received flag is cleared only by writing 0, and a nonzero write to it is ignored. A write to the receive-data word (word 0x146) is ignored.
- R11: While the receiver is started, `rx_valid` latches `rx_data` into the receive-data word and sets the byte-received flag. While the receiver is stopped, `rx_valid` has no effect.
- R12: After reset, the following hold:
  - the four pin-select words (0x142 to 0x145) read all ones and are plain read/write storage;
  - the baud word (word 0x149) reads 0x04000000;
  - every other word, the mask, the flags, the started, pending and enabled states, and `irq` are zero;
  - a byte in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request, data on the next edge |
| bus_wr | input | 1 | Write request |
| bus_addr | input | 9 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| tx_byte | output | 8 | Byte handed to the transmit shifter |
| tx_active | output | 1 | A byte is pending |
| tx_done | output | 1 | Send-done pulse from the transmit stub |
| rx_valid | input | 1 | A byte arrived from the receive buffer |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition detected |
| rx_running | output | 1 | Receiver-started state |

## Verification
A wrong enable or started state shows up on the first bus access after it goes wrong. A read then returns nonzero data while the peripheral is off, or `rx_running` and `tx_active` take a value the task history does not allow, at the next sample. A wrong flag or mask shows on `irq` on the same edge as the bad update. Because `irq` is registered, a lag or early change of one cycle is visible there and is checked. A transmit stub with a wrong count moves `tx_done` and the byte-sent flag away from the exact edge the bench predicts from TX_CYCLES.

// File: rtl/uart_taskreg_pkg.sv
`timescale 1ns/1ps
package uart_taskreg_pkg;
  localparam int ADDR_W   = 9;
  localparam int DATA_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int NUM_EV   = 4;
  localparam int NUM_PSEL = 4;
  localparam int ERR_W    = 2;

  // event bit positions, shared by flags and mask
  localparam int EV_RXDRDY = 0;
  localparam int EV_TXDRDY = 1;
  localparam int EV_ERROR  = 2;
  localparam int EV_RXTO   = 3;

  // word addresses
  localparam logic [ADDR_W-1:0] A_STARTRX  = 9'h000;
  localparam logic [ADDR_W-1:0] A_STOPRX   = 9'h001;
  localparam logic [ADDR_W-1:0] A_STARTTX  = 9'h002;
  localparam logic [ADDR_W-1:0] A_STOPTX   = 9'h003;
  localparam logic [ADDR_W-1:0] A_SUSPEND  = 9'h007;
  localparam logic [ADDR_W-1:0] A_EV_RXRDY = 9'h042;
  localparam logic [ADDR_W-1:0] A_EV_TXRDY = 9'h047;
  localparam logic [ADDR_W-1:0] A_EV_ERR   = 9'h049;
  localparam logic [ADDR_W-1:0] A_EV_RXTO  = 9'h051;
  localparam logic [ADDR_W-1:0] A_MASK     = 9'h0C0;
  localparam logic [ADDR_W-1:0] A_MASKSET  = 9'h0C1;
  localparam logic [ADDR_W-1:0] A_MASKCLR  = 9'h0C2;
  localparam logic [ADDR_W-1:0] A_ERRSRC   = 9'h120;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 9'h140;
  localparam logic [ADDR_W-1:0] A_PSEL0    = 9'h142;
  localparam logic [ADDR_W-1:0] A_RXD      = 9'h146;
  localparam logic [ADDR_W-1:0] A_TXD      = 9'h147;
  localparam logic [ADDR_W-1:0] A_BAUD     = 9'h149;

  localparam logic [DATA_W-1:0] EN_CODE  = 32'd4;
  localparam logic [DATA_W-1:0] PSEL_RST = '1;
  localparam logic [DATA_W-1:0] BAUD_RST = 32'h0400_0000;

  typedef struct packed {
    logic                start_rx;
    logic                start_tx;
    logic                stop_rx;
    logic                stop_tx;
    logic                en_on;
    logic                en_off;
    logic                txd_wr;
    logic                mask_wr;
    logic                mask_set;
    logic                mask_clr;
    logic                err_w1c;
    logic                baud_wr;
    logic [NUM_PSEL-1:0] psel_wr;
    logic [NUM_EV-1:0]   ev_wr;
    logic [NUM_EV-1:0]   ev_val;
  } strobe_t;

  function automatic logic [ADDR_W-1:0] ev_addr(input int idx);
    case (idx)
      EV_RXDRDY: return A_EV_RXRDY;
      EV_TXDRDY: return A_EV_TXRDY;
      EV_ERROR:  return A_EV_ERR;
      default:   return A_EV_RXTO;
    endcase
  endfunction
endpackage

// File: rtl/uart_task_decode.sv
`timescale 1ns/1ps
module uart_task_decode
  import uart_taskreg_pkg::*;
(
  input  logic              enabled,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output strobe_t           st
);
  logic acc, is_one, is_zero, en_hit;

  always_comb begin
    en_hit  = bus_wr && (bus_addr == A_ENABLE);
    acc     = bus_wr && (enabled || (bus_addr == A_ENABLE));
    is_one  = (bus_wdata == 32'd1);
    is_zero = (bus_wdata == '0);

    st          = '0;
    st.en_on    = en_hit && (bus_wdata == EN_CODE);
    st.en_off   = en_hit && is_zero;
    st.start_rx = acc && (bus_addr == A_STARTRX) && is_one;
    st.start_tx = acc && (bus_addr == A_STARTTX) && is_one;
    st.stop_rx  = (acc && is_one && ((bus_addr == A_STOPRX) || (bus_addr == A_SUSPEND)))
                || st.en_off;
    st.stop_tx  = (acc && is_one && ((bus_addr == A_STOPTX) || (bus_addr == A_SUSPEND)))
                || st.en_off;
    st.txd_wr   = acc && (bus_addr == A_TXD);
    st.mask_wr  = acc && (bus_addr == A_MASK);
    st.mask_set = acc && (bus_addr == A_MASKSET);
    st.mask_clr = acc && (bus_addr == A_MASKCLR);
    st.err_w1c  = acc && (bus_addr == A_ERRSRC);
    st.baud_wr  = acc && (bus_addr == A_BAUD);

    for (int p = 0; p < NUM_PSEL; p++)
      st.psel_wr[p] = acc && (bus_addr == A_PSEL0 + ADDR_W'(p));

    for (int e = 0; e < NUM_EV; e++) begin
      if (e == EV_RXDRDY) begin
        // this flag can only be cleared from the bus
        st.ev_wr[e]  = acc && (bus_addr == ev_addr(e)) && is_zero;
        st.ev_val[e] = 1'b0;
      end else begin
        st.ev_wr[e]  = acc && (bus_addr == ev_addr(e));
        st.ev_val[e] = !is_zero;
      end
    end
  end
endmodule

// File: rtl/uart_event_bank.sv
`timescale 1ns/1ps
module uart_event_bank #(
  parameter int NEV = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] hw_set,
  input  logic [NEV-1:0] sw_wr,
  input  logic [NEV-1:0] sw_val,
  input  logic           mask_wr,
  input  logic           mask_set,
  input  logic           mask_clr,
  input  logic [NEV-1:0] mask_din,
  output logic [NEV-1:0] flags,
  output logic [NEV-1:0] mask,
  output logic           irq
);
  logic [NEV-1:0] flag_d;
  logic [NEV-1:0] mask_d;

  for (genvar g = 0; g < NEV; g++) begin : g_flag
    // a hardware set in the same cycle wins over a bus write
    always_comb flag_d[g] = hw_set[g] ? 1'b1 : (sw_wr[g] ? sw_val[g] : flags[g]);

    always_ff @(posedge clk) begin
      if (rst) flags[g] <= 1'b0;
      else     flags[g] <= flag_d[g];
    end
  end

  always_comb begin
    mask_d = mask;
    if (mask_wr)       mask_d = mask_din;
    else if (mask_set) mask_d = mask | mask_din;
    else if (mask_clr) mask_d = mask & ~mask_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      mask <= mask_d;
      irq  <= |(flag_d & mask_d);
    end
  end
endmodule

// File: rtl/uart_tx_stub.sv
`timescale 1ns/1ps
module uart_tx_stub #(
  parameter int TX_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(TX_CYCLES + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= CW'(TX_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_taskreg_ctrl.sv
`timescale 1ns/1ps
module uart_taskreg_ctrl
  import uart_taskreg_pkg::*;
#(
  parameter int TX_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_active,
  output logic              tx_done,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_running
);
  strobe_t           st;
  logic              enabled;
  logic              tx_started;
  logic              tx_accept;
  logic [NUM_EV-1:0] hw_set;
  logic [NUM_EV-1:0] ev_flags;
  logic [NUM_EV-1:0] int_mask;
  logic [ERR_W-1:0]  errsrc;
  logic [BYTE_W-1:0] rxd_q;
  logic [DATA_W-1:0] baud_q;
  logic [DATA_W-1:0] psel_q [NUM_PSEL];
  logic [DATA_W-1:0] rd_val;

  uart_task_decode i_dec (
    .enabled   (enabled),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .st        (st)
  );

  assign tx_accept = st.txd_wr && tx_started && !tx_active;

  uart_tx_stub #(.TX_CYCLES(TX_CYCLES)) i_tx (
    .clk   (clk),
    .rst   (rst),
    .start (tx_accept),
    .done  (tx_done)
  );

  always_comb begin
    hw_set            = '0;
    hw_set[EV_RXDRDY] = rx_valid && rx_running;
    hw_set[EV_TXDRDY] = tx_done;
    hw_set[EV_ERROR]  = rx_break;
    hw_set[EV_RXTO]   = st.stop_rx;
  end

  uart_event_bank #(.NEV(NUM_EV)) i_ev (
    .clk      (clk),
    .rst      (rst),
    .hw_set   (hw_set),
    .sw_wr    (st.ev_wr),
    .sw_val   (st.ev_val),
    .mask_wr  (st.mask_wr),
    .mask_set (st.mask_set),
    .mask_clr (st.mask_clr),
    .mask_din (bus_wdata[NUM_EV-1:0]),
    .flags    (ev_flags),
    .mask     (int_mask),
    .irq      (irq)
  );

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      enabled    <= 1'b0;
      rx_running <= 1'b0;
      tx_started <= 1'b0;
      tx_active  <= 1'b0;
      tx_byte    <= '0;
      rxd_q      <= '0;
      errsrc     <= '0;
    end else begin
      if (st.en_on)       enabled <= 1'b1;
      else if (st.en_off) enabled <= 1'b0;

      if (st.stop_rx)       rx_running <= 1'b0;
      else if (st.start_rx) rx_running <= 1'b1;

      if (st.stop_tx)       tx_started <= 1'b0;
      else if (st.start_tx) tx_started <= 1'b1;

      if (tx_accept) begin
        tx_active <= 1'b1;
        tx_byte   <= bus_wdata[BYTE_W-1:0];
      end else if (tx_done) begin
        tx_active <= 1'b0;
      end

      if (rx_valid && rx_running) rxd_q <= rx_data;

      if (rx_break)        errsrc <= '1;
      else if (st.err_w1c) errsrc <= errsrc & ~bus_wdata[ERR_W-1:0];
    end
  end

  // plain storage words
  for (genvar g = 0; g < NUM_PSEL; g++) begin : g_psel
    always_ff @(posedge clk) begin
      if (rst)                 psel_q[g] <= PSEL_RST;
      else if (st.psel_wr[g])  psel_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             baud_q <= BAUD_RST;
    else if (st.baud_wr) baud_q <= bus_wdata;
  end

  // read path
  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_MASK, A_MASKSET, A_MASKCLR: rd_val = DATA_W'(int_mask);
      A_ERRSRC: rd_val = DATA_W'(errsrc);
      A_ENABLE: rd_val = enabled ? EN_CODE : '0;
      A_RXD:    rd_val = DATA_W'(rxd_q);
      A_TXD:    rd_val = DATA_W'(tx_byte);
      A_BAUD:   rd_val = baud_q;
      default: begin
        for (int e = 0; e < NUM_EV; e++)
          if (bus_addr == ev_addr(e)) rd_val = DATA_W'(ev_flags[e]);
        for (int p = 0; p < NUM_PSEL; p++)
          if (bus_addr == A_PSEL0 + ADDR_W'(p)) rd_val = psel_q[p];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= enabled ? rd_val : '0;
  end
endmodule

// File: rtl/uart_taskreg_chk.sv
`timescale 1ns/1ps
module uart_taskreg_chk
  import uart_taskreg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              tx_active,
  input logic              tx_done,
  input logic              rx_break,
  input logic              rx_running,
  input logic              enabled,
  input logic [NUM_EV-1:0] ev_flags,
  input logic [NUM_EV-1:0] int_mask,
  input logic [ERR_W-1:0]  errsrc
);
  p_enable_code_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_ENABLE && bus_wdata == EN_CODE) |=> enabled);

  p_bad_code_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_ENABLE && bus_wdata != '0 && bus_wdata != EN_CODE)
      |=> $stable(enabled));

  p_rd_zero_off_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !enabled) |=> (bus_rdata == '0));

  p_wr_ignored_off_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !enabled && bus_addr != A_ENABLE) |=> $stable(int_mask));

  p_irq_follows_r4: assert property (@(posedge clk) disable iff (rst)
    irq == |(ev_flags & int_mask));

  p_stoprx_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && enabled && bus_addr == A_STOPRX && bus_wdata == 32'd1)
      |=> (ev_flags[EV_RXTO] && !rx_running));

  p_txd_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_TXD && tx_active) |=> $stable(tx_byte));

  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> (!tx_active && ev_flags[EV_TXDRDY]));

  p_break_r9: assert property (@(posedge clk) disable iff (rst)
    rx_break |=> (ev_flags[EV_ERROR] && errsrc == 2'b11));
endmodule

bind uart_taskreg_ctrl uart_taskreg_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .tx_byte    (tx_byte),
  .tx_active  (tx_active),
  .tx_done    (tx_done),
  .rx_break   (rx_break),
  .rx_running (rx_running),
  .enabled    (enabled),
  .ev_flags   (ev_flags),
  .int_mask   (int_mask),
  .errsrc     (errsrc)
);

// File: tb/test_uart_taskreg_ctrl.sv
`timescale 1ns/1ps
module test_uart_taskreg_ctrl;
  import uart_taskreg_pkg::*;

  localparam int TXC = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_active;
  logic              tx_done;
  logic              rx_valid = 1'b0;
  logic [BYTE_W-1:0] rx_data = '0;
  logic              rx_break = 1'b0;
  logic              rx_running;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  uart_taskreg_ctrl #(.TX_CYCLES(TXC)) i_uart_taskreg_ctrl (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_byte(tx_byte),
    .tx_active(tx_active), .tx_done(tx_done), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_running(rx_running)
  );

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b1, A_PSEL0,    32'h0,          4'd2},   // R2 read while off
    '{1'b0, A_MASK,     32'hF,          4'd2},   // R2 ignored write
    '{1'b0, A_ENABLE,   32'd3,          4'd1},   // R1 bad code
    '{1'b1, A_BAUD,     32'h0,          4'd1},   // R1 still off
    '{1'b0, A_ENABLE,   32'd4,          4'd1},   // R1 good code
    '{1'b1, A_MASK,     32'h0,          4'd2},   // R2 mask untouched
    '{1'b1, A_PSEL0,    32'hFFFF_FFFF,  4'd12},  // R12
    '{1'b1, A_BAUD,     32'h0400_0000,  4'd12},  // R12
    '{1'b0, A_MASK,     32'h5,          4'd3},   // R3
    '{1'b1, A_MASK,     32'h5,          4'd3},
    '{1'b0, A_MASKSET,  32'h2,          4'd3},
    '{1'b1, A_MASKCLR,  32'h7,          4'd3},
    '{1'b0, A_MASKCLR,  32'h4,          4'd3},
    '{1'b1, A_MASKSET,  32'h3,          4'd3},
    '{1'b0, A_STOPRX,   32'd1,          4'd6},   // R6
    '{1'b1, A_EV_RXTO,  32'd1,          4'd6},
    '{1'b0, A_EV_RXTO,  32'd0,          4'd10},  // R10
    '{1'b1, A_EV_RXTO,  32'd0,          4'd10},
    '{1'b0, A_EV_TXRDY, 32'd5,          4'd10},
    '{1'b1, A_EV_TXRDY, 32'd1,          4'd10},
    '{1'b0, A_EV_TXRDY, 32'd0,          4'd10},
    '{1'b0, A_RXD,      32'h55,         4'd10},
    '{1'b1, A_RXD,      32'h0,          4'd10},
    '{1'b0, A_PSEL0+9'd1, 32'h12,       4'd12},
    '{1'b1, A_PSEL0+9'd1, 32'h12,       4'd12},
    '{1'b0, A_ENABLE,   32'd7,          4'd1},   // R1 other code keeps on
    '{1'b1, A_BAUD,     32'h0400_0000,  4'd1},
    '{1'b1, A_ERRSRC,   32'h0,          4'd9}    // R9
  };

  task automatic chk(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    logic [DATA_W-1:0] v;
    rd(a, v);
    chk(tag, v, e);
  endtask

  task automatic pulse_rx(input logic [BYTE_W-1:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 irq after reset", 32'(irq), 32'd0);
    chk("R12 rx_running after reset", 32'(rx_running), 32'd0);
    chk("R12 tx_active after reset", 32'(tx_active), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rd_chk(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec%0d", VEC[i].req, i));
      else           wr(VEC[i].addr, VEC[i].data);
    end

    // R5 start codes
    wr(A_STARTRX, 32'd2);
    chk("R5 start with 2", 32'(rx_running), 32'd0);
    wr(A_STARTRX, 32'd1);
    chk("R5 start with 1", 32'(rx_running), 32'd1);

    // R11 receive, R4 irq, R10 byte-received clear rule
    pulse_rx(8'hA5);
    chk("R4 irq on rx flag", 32'(irq), 32'd1);
    rd_chk(A_RXD, 32'hA5, "R11 rx byte");
    rd_chk(A_EV_RXRDY, 32'd1, "R11 rx flag");
    wr(A_EV_RXRDY, 32'd1);
    rd_chk(A_EV_RXRDY, 32'd1, "R10 nonzero ignored");
    wr(A_EV_RXRDY, 32'd0);
    chk("R4 irq drops", 32'(irq), 32'd0);
    rd_chk(A_EV_RXRDY, 32'd0, "R10 zero clears");

    wr(A_STOPRX, 32'd1);
    pulse_rx(8'h3C);
    rd_chk(A_RXD, 32'hA5, "R11 byte ignored when stopped");
    rd_chk(A_EV_RXRDY, 32'd0, "R11 flag untouched when stopped");
    wr(A_EV_RXTO, 32'd0);

    // R7 transmit gating
    wr(A_TXD, 32'h33);
    chk("R7 not started", 32'(tx_active), 32'd0);
    rd_chk(A_TXD, 32'h0, "R7 byte not latched");
    wr(A_MASK, 32'h2);
    wr(A_STARTTX, 32'd1);
    wr(A_TXD, 32'h3C);
    chk("R7 accepted active", 32'(tx_active), 32'd1);
    chk("R7 accepted byte", 32'(tx_byte), 32'h3C);
    // R8 exact completion timing
    repeat (TXC - 1) @(negedge clk);
    chk("R8 done not early", 32'(tx_done), 32'd0);
    @(negedge clk);
    chk("R8 done pulse", 32'(tx_done), 32'd1);
    chk("R8 flag not yet", 32'(irq), 32'd0);
    @(negedge clk);
    chk("R8 flag and irq", 32'(irq), 32'd1);
    chk("R8 pending cleared", 32'(tx_active), 32'd0);
    wr(A_TXD, 32'h5A);
    chk("R8 next byte accepted", 32'(tx_byte), 32'h5A);
    wr(A_TXD, 32'h77);
    chk("R7 dropped while pending", 32'(tx_byte), 32'h5A);
    repeat (TXC + 2) @(negedge clk);
    chk("R8 second done", 32'(tx_active), 32'd0);
    wr(A_EV_TXRDY, 32'd0);

    // R6 stop-transmit and suspend
    wr(A_STARTRX, 32'd1);
    wr(A_STOPTX, 32'd1);
    chk("R6 stoptx keeps rx", 32'(rx_running), 32'd1);
    rd_chk(A_EV_RXTO, 32'd0, "R6 stoptx no timeout");
    wr(A_TXD, 32'h11);
    chk("R6 stoptx stops tx", 32'(tx_active), 32'd0);
    wr(A_STARTTX, 32'd1);
    wr(A_SUSPEND, 32'd1);
    chk("R6 suspend stops rx", 32'(rx_running), 32'd0);
    rd_chk(A_EV_RXTO, 32'd1, "R6 suspend timeout");
    wr(A_TXD, 32'h22);
    chk("R6 suspend stops tx", 32'(tx_active), 32'd0);
    wr(A_EV_RXTO, 32'd0);

    // R9 break and error source
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd_chk(A_ERRSRC, 32'h3, "R9 break bits");
    rd_chk(A_EV_ERR, 32'd1, "R9 error flag");
    wr(A_ERRSRC, 32'h1);
    rd_chk(A_ERRSRC, 32'h2, "R9 w1c");
    @(negedge clk);
    rx_break = 1'b1; bus_wr = 1'b1; bus_addr = A_ERRSRC; bus_wdata = 32'h3;
    @(negedge clk);
    rx_break = 1'b0; bus_wr = 1'b0;
    rd_chk(A_ERRSRC, 32'h3, "R9 break wins over clear");
    wr(A_EV_ERR, 32'd0);

    // R1 disable acts as stop, R2 gating while off
    wr(A_MASK, 32'h8);
    wr(A_STARTRX, 32'd1);
    chk("R1 irq before disable", 32'(irq), 32'd0);
    wr(A_ENABLE, 32'd0);
    chk("R1 disable stops rx", 32'(rx_running), 32'd0);
    chk("R1 disable raises timeout irq", 32'(irq), 32'd1);
    rd_chk(A_MASK, 32'd0, "R2 read zero when off");
    wr(A_MASKCLR, 32'h8);
    wr(A_ENABLE, 32'd4);
    rd_chk(A_MASK, 32'h8, "R2 clear ignored when off");

    // R12 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R12 irq cleared", 32'(irq), 32'd0);
    wr(A_ENABLE, 32'd4);
    rd_chk(A_PSEL0 + 9'd1, 32'hFFFF_FFFF, "R12 pin select restored");
    rd_chk(A_MASK, 32'd0, "R12 mask cleared");
    rd_chk(A_EV_RXTO, 32'd0, "R12 flag cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule